// File: doc/BRIEF.md
# Pin Function Multiplexer with Signal Overrides

This block sits between a bank of general-purpose pads and the peripherals that share them. Every pin owns one control word. The word holds a function code that connects the pin to one peripheral. That peripheral's output and output-enable then drive the pad, and the pad's input is returned to the same peripheral. Four independent two-bit override fields follow the routing stage. They can invert or force the output, the output enable, the input delivered to the peripheral, and the per-pin interrupt signal.

Peripherals appear as generic lane vectors. Each function has `NUM_LANES` lanes, and pin `p` uses lane `p % NUM_LANES`. Several pins therefore map to the same lane of a function. When more than one of those pins selects the function, the peripheral input for that lane is the OR of their inputs. Software reaches the control words through a plain register bus with one 32-bit word per pin. The bus has no handshake. A write completes in a single cycle, and read data is registered.

Top module: `iomux_bank`

## Requirements
- R1: After reset, every control word reads `0x1F` in bits [4:0] with all override fields at 0. Bit 31 of a read carries the raw pad input. `pad_out`, `pad_oe` and `fn_in` are all zero.
- R2: A write replaces the whole control word and is visible from the next cycle. The fields are: function in bits [4:0], output override in [9:8], output-enable override in [13:12], input override in [17:16] and interrupt override in [21:20]. All other written bits are dropped and read back as 0. A write that carries only a function code therefore leaves all four overrides at 0 (normal). Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R3: A function code `f` below 10 routes `fn_out[f*NUM_LANES+lane]` to `pad_out` and `fn_oe[f*NUM_LANES+lane]` to `pad_oe`, combinationally. Here lane = pin % NUM_LANES. Codes 0 to 9 cover the ten peripheral slots.
- R4: Function codes 10 to 31 connect nothing. 0x1F is the designated null code. The selected output and output enable are 0, and the pin adds nothing to any `fn_in` bit. Overrides still apply to such a pin.
- R5: The output override works as follows: 0 passes the selected output, 1 inverts it, 2 forces `pad_out` low and 3 forces it high.
- R6: The output-enable override uses the same codes on `pad_oe`: 0 passes, 1 inverts, 2 disables the output and 3 enables it.
- R7: The input override uses the same codes on the pad input value that is delivered to the selected peripheral.
- R8: `pin_irq[p]` is the raw `pad_in[p]` passed through that pin's interrupt override, using the same codes. It does not depend on the function code.
- R9: `fn_in[f*NUM_LANES+l]` is the OR of the overridden inputs of every pin with lane `l` whose function is `f`. A pin that does not select `f` contributes 0.
- R10: Read-data bit 31 is the raw `pad_in` of the addressed pin, sampled in the read cycle. It does not depend on that pin's function or overrides.
- R11: A write to an address at or above `NUM_PINS` changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one control word |
| bus_rd | input | 1 | Read strobe for one control word |
| bus_addr | input | ADDR_W (5) | Word index = pin number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_PINS (30) | Raw input from each pad |
| pad_out | output | NUM_PINS | Output value to each pad |
| pad_oe | output | NUM_PINS | Output enable to each pad |
| pin_irq | output | NUM_PINS | Per-pin interrupt signal after override |
| fn_out | input | NUM_FUNCS*NUM_LANES (80) | Peripheral outputs, function-major lanes |
| fn_oe | input | NUM_FUNCS*NUM_LANES | Peripheral output enables |
| fn_in | output | NUM_FUNCS*NUM_LANES | Gathered peripheral inputs |

## Verification
`pad_out`, `pad_oe`, `pin_irq` and `fn_in` are combinational from the stored control words and the live pad and peripheral vectors. They are due in the same cycle as an input change, and one cycle after the edge that accepts a write. Read data is due one edge after the read request. The bench drives stimulus just after a rising edge, advances its behavioural model on that edge, and compares every output on the falling edge. The read result is therefore compared half a cycle after the edge that captured it. Directed sequences cover the override codes, null and unsupported functions, lane sharing and out-of-range addresses. A long random phase follows, compared cycle by cycle.

// File: rtl/iomux_pkg.sv
`timescale 1ns/1ps
package iomux_pkg;

  localparam logic [4:0] FSEL_NULL = 5'h1F;
  localparam int PAD_BIT = 31;

  typedef enum logic [1:0] {
    OVR_PASS = 2'd0,
    OVR_INV  = 2'd1,
    OVR_LOW  = 2'd2,
    OVR_HIGH = 2'd3
  } ovr_e;

  typedef struct packed {
    ovr_e       irq;
    ovr_e       inp;
    ovr_e       oe;
    ovr_e       out;
    logic [4:0] fsel;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{irq: OVR_PASS, inp: OVR_PASS, oe: OVR_PASS,
                                     out: OVR_PASS, fsel: FSEL_NULL};

  function automatic logic apply_ovr(input logic v, input ovr_e o);
    case (o)
      OVR_PASS: return v;
      OVR_INV:  return ~v;
      OVR_LOW:  return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction

  function automatic pin_cfg_t word_to_cfg(input logic [31:0] w);
    pin_cfg_t c;
    c.fsel = w[4:0];
    c.out  = ovr_e'(w[9:8]);
    c.oe   = ovr_e'(w[13:12]);
    c.inp  = ovr_e'(w[17:16]);
    c.irq  = ovr_e'(w[21:20]);
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[4:0]   = c.fsel;
    w[9:8]   = c.out;
    w[13:12] = c.oe;
    w[17:16] = c.inp;
    w[21:20] = c.irq;
    return w;
  endfunction

endpackage

// File: rtl/iomux_regs.sv
`timescale 1ns/1ps
module iomux_regs
  import iomux_pkg::*;
#(
  parameter int NUM_PINS = 30,
  parameter int ADDR_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic [NUM_PINS-1:0]      pad_in,
  output pin_cfg_t [NUM_PINS-1:0]  cfg,
  output logic [31:0]              bus_rdata
);

  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [31:0]             rdata_q;
  logic                    in_range;
  logic                    pad_at_addr;

  assign in_range    = ({1'b0, bus_addr} < (ADDR_W+1)'(NUM_PINS));
  assign pad_at_addr = in_range ? pad_in[bus_addr] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= CFG_RESET;
    end else if (bus_wr && in_range) begin
      cfg_q[bus_addr] <= word_to_cfg(bus_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      if (in_range) begin
        rdata_q          <= cfg_to_word(cfg_q[bus_addr]);
        rdata_q[PAD_BIT] <= pad_at_addr;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign cfg       = cfg_q;
  assign bus_rdata = rdata_q;

  // R11: writes outside the bank leave every control word untouched
  a_r11_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !in_range) |=> $stable(cfg_q));

  // R11: reads outside the bank return zero
  a_r11_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !in_range) |=> (bus_rdata == 32'h0));

  // R10: status bit mirrors the raw pad captured at the read
  a_r10_raw_pad_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_range) |=> (bus_rdata[PAD_BIT] == $past(pad_at_addr)));

endmodule

// File: rtl/iomux_pin.sv
`timescale 1ns/1ps
module iomux_pin
  import iomux_pkg::*;
#(
  parameter int NUM_FUNCS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pin_cfg_t             cfg,
  input  logic [NUM_FUNCS-1:0] lane_out,
  input  logic [NUM_FUNCS-1:0] lane_oe,
  input  logic                 pad_in,
  output logic                 pad_out,
  output logic                 pad_oe,
  output logic                 pin_irq,
  output logic                 in_val,
  output logic [NUM_FUNCS-1:0] fsel_hit
);

  localparam int FW = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

  logic          fsel_ok;
  logic [FW-1:0] fidx;
  logic          sel_out;
  logic          sel_oe;

  assign fsel_ok = (int'(cfg.fsel) < NUM_FUNCS);
  assign fidx    = cfg.fsel[FW-1:0];

  always_comb begin
    sel_out  = 1'b0;
    sel_oe   = 1'b0;
    fsel_hit = '0;
    if (fsel_ok) begin
      sel_out        = lane_out[fidx];
      sel_oe         = lane_oe[fidx];
      fsel_hit[fidx] = 1'b1;
    end
  end

  assign pad_out = apply_ovr(sel_out, cfg.out);
  assign pad_oe  = apply_ovr(sel_oe,  cfg.oe);
  assign in_val  = apply_ovr(pad_in,  cfg.inp);
  assign pin_irq = apply_ovr(pad_in,  cfg.irq);

  // R5: forced output codes win over any routed value
  a_r5_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.out == OVR_LOW) |-> !pad_out);
  a_r5_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.out == OVR_HIGH) |-> pad_out);

  // R4: unsupported codes enable nothing unless an override does
  a_r4_null_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsel_ok && cfg.oe == OVR_PASS) |-> !pad_oe);
  a_r4_null_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !fsel_ok |-> (fsel_hit == '0));

  // R3: a pin feeds at most one function
  a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fsel_hit));

endmodule

// File: rtl/iomux_gather.sv
`timescale 1ns/1ps
module iomux_gather #(
  parameter int NUM_PINS  = 30,
  parameter int NUM_FUNCS = 10,
  parameter int NUM_LANES = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_FUNCS-1:0]           fsel_hit [NUM_PINS],
  input  logic [NUM_PINS-1:0]            in_val,
  output logic [NUM_FUNCS*NUM_LANES-1:0] fn_in
);

  localparam int FN_W = NUM_FUNCS * NUM_LANES;

  always_comb begin
    fn_in = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int f = 0; f < NUM_FUNCS; f++) begin
        fn_in[f*NUM_LANES + (p % NUM_LANES)] = fn_in[f*NUM_LANES + (p % NUM_LANES)]
                                               | (fsel_hit[p][f] & in_val[p]);
      end
    end
  end

  // R9: with no pin selecting any function, every gathered input is low
  logic any_hit;
  always_comb begin
    any_hit = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) any_hit = any_hit | (|fsel_hit[p]);
  end

  a_r9_idle_gather_low: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> (fn_in == FN_W'(0)));

endmodule

// File: rtl/iomux_bank.sv
`timescale 1ns/1ps
module iomux_bank
  import iomux_pkg::*;
#(
  parameter int NUM_PINS  = 30,
  parameter int NUM_FUNCS = 10,
  parameter int NUM_LANES = 8,
  parameter int ADDR_W    = $clog2(NUM_PINS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  input  logic [NUM_PINS-1:0]            pad_in,
  output logic [NUM_PINS-1:0]            pad_out,
  output logic [NUM_PINS-1:0]            pad_oe,
  output logic [NUM_PINS-1:0]            pin_irq,
  input  logic [NUM_FUNCS*NUM_LANES-1:0] fn_out,
  input  logic [NUM_FUNCS*NUM_LANES-1:0] fn_oe,
  output logic [NUM_FUNCS*NUM_LANES-1:0] fn_in
);

  pin_cfg_t [NUM_PINS-1:0] cfg;
  logic [NUM_FUNCS-1:0]    fsel_hit [NUM_PINS];
  logic [NUM_PINS-1:0]     in_val;

  iomux_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_in    (pad_in),
    .cfg       (cfg),
    .bus_rdata (bus_rdata)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int LANE = p % NUM_LANES;
    logic [NUM_FUNCS-1:0] lane_out;
    logic [NUM_FUNCS-1:0] lane_oe;

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_lane
      assign lane_out[f] = fn_out[f*NUM_LANES + LANE];
      assign lane_oe[f]  = fn_oe[f*NUM_LANES + LANE];
    end

    iomux_pin #(.NUM_FUNCS(NUM_FUNCS)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg[p]),
      .lane_out (lane_out),
      .lane_oe  (lane_oe),
      .pad_in   (pad_in[p]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .pin_irq  (pin_irq[p]),
      .in_val   (in_val[p]),
      .fsel_hit (fsel_hit[p])
    );
  end

  iomux_gather #(
    .NUM_PINS  (NUM_PINS),
    .NUM_FUNCS (NUM_FUNCS),
    .NUM_LANES (NUM_LANES)
  ) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsel_hit (fsel_hit),
    .in_val   (in_val),
    .fn_in    (fn_in)
  );

endmodule

// File: tb/test_iomux_bank.sv
`timescale 1ns/1ps
module test_iomux_bank;

  localparam int NP = 30;
  localparam int NF = 10;
  localparam int NL = 8;
  localparam int FN = NF * NL;
  localparam logic [31:0] WMASK = 32'h0033_331F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pin_irq;
  logic [FN-1:0] fn_out = '0;
  logic [FN-1:0] fn_oe = '0;
  logic [FN-1:0] fn_in;

  always #5 clk = ~clk;

  iomux_bank i_iomux_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_irq(pin_irq),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [NP];
  logic [31:0] m_rdata;

  function automatic bit ovr(input bit v, input int code);
    case (code)
      0: return v;
      1: return !v;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) m_reg[p] <= 32'h1F;
      m_rdata <= 32'h0;
    end else begin
      if (bus_wr && int'(bus_addr) < NP) m_reg[bus_addr] <= bus_wdata & WMASK;
      if (bus_rd) begin
        if (int'(bus_addr) < NP) m_rdata <= m_reg[bus_addr] | (32'(pad_in[bus_addr]) << 31);
        else m_rdata <= 32'h0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NP-1:0] e_out, e_oe, e_irq;
      logic [FN-1:0] e_in;
      e_in = '0;
      for (int p = 0; p < NP; p++) begin
        int w, fs, ln;
        bit so, se;
        w  = int'(m_reg[p]);
        fs = w & 31;
        ln = p % NL;
        so = (fs < NF) ? fn_out[fs*NL+ln] : 1'b0;
        se = (fs < NF) ? fn_oe[fs*NL+ln]  : 1'b0;
        e_out[p] = ovr(so, (w >> 8) & 3);
        e_oe[p]  = ovr(se, (w >> 12) & 3);
        e_irq[p] = ovr(pad_in[p], (w >> 20) & 3);
        if (fs < NF) e_in[fs*NL+ln] = e_in[fs*NL+ln] | ovr(pad_in[p], (w >> 16) & 3);
      end
      chk("R3 R5 pad_out", 128'(pad_out), 128'(e_out));
      chk("R4 R6 pad_oe", 128'(pad_oe), 128'(e_oe));
      chk("R8 pin_irq", 128'(pin_irq), 128'(e_irq));
      chk("R7 R9 fn_in", 128'(fn_in), 128'(e_in));
      chk("R2 R10 bus_rdata", 128'(bus_rdata), 128'(m_rdata));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = 5'(a);
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, keep;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    // R1
    chk("R1 pad_oe", 128'(pad_oe), 128'(0));
    chk("R1 pad_out", 128'(pad_out), 128'(0));
    chk("R1 fn_in", 128'(fn_in), 128'(0));
    rd(0, d);  chk("R1 reset word", 128'(d), 128'(32'h1F));
    pad_in = '1;
    rd(29, d); chk("R1 R10 reset word pad", 128'(d), 128'(32'h8000_001F));
    // R2
    wr(3, 32'hFFFF_FFE5);
    rd(3, d);  chk("R2 masked word", 128'(d), 128'(32'h8033_3305));
    wr(3, 32'h5);
    rd(3, d);  chk("R2 overrides cleared", 128'(d), 128'(32'h8000_0005));
    // R3
    pad_in = '0; fn_out = '0; fn_oe = '0;
    fn_out[43] = 1'b1; fn_oe[43] = 1'b1; settle();
    chk("R3 route out", 128'(pad_out[3]), 128'(1));
    chk("R3 route oe", 128'(pad_oe[3]), 128'(1));
    fn_out[43] = 1'b0; settle();
    chk("R3 route out low", 128'(pad_out[3]), 128'(0));
    // R5
    wr(3, 32'h0000_0105); settle();
    chk("R5 invert", 128'(pad_out[3]), 128'(1));
    fn_out[43] = 1'b1; wr(3, 32'h0000_0205); settle();
    chk("R5 force low", 128'(pad_out[3]), 128'(0));
    // R6
    fn_oe[43] = 1'b1; wr(3, 32'h0000_2005); settle();
    chk("R6 disable", 128'(pad_oe[3]), 128'(0));
    fn_oe[43] = 1'b0; wr(3, 32'h0000_3005); settle();
    chk("R6 enable", 128'(pad_oe[3]), 128'(1));
    // R4
    fn_out = '1; fn_oe = '1; pad_in = '1; wr(3, 32'h1F);
    wr(4, 32'h0000_000A); settle();
    chk("R4 unsupported out", 128'(pad_out[4]), 128'(0));
    chk("R4 unsupported oe", 128'(pad_oe[4]), 128'(0));
    chk("R4 no input", 128'(fn_in), 128'(0));
    wr(4, 32'h0000_031F); settle();
    chk("R4 override on null", 128'(pad_out[4]), 128'(1));
    // R7
    fn_out = '0; fn_oe = '0; pad_in = '0; pad_in[3] = 1'b1;
    wr(3, 32'h0001_0005); settle();
    chk("R7 invert input", 128'(fn_in[43]), 128'(0));
    pad_in[3] = 1'b0; wr(3, 32'h0003_0005); settle();
    chk("R7 force input high", 128'(fn_in[43]), 128'(1));
    // R8
    wr(6, 32'h0010_001F); settle();
    chk("R8 irq invert", 128'(pin_irq[6]), 128'(1));
    pad_in[6] = 1'b1; settle();
    chk("R8 irq invert hi", 128'(pin_irq[6]), 128'(0));
    // R9
    wr(3, 32'h1F); pad_in = '0;
    wr(1, 32'h2); wr(9, 32'h2); wr(17, 32'h3);
    pad_in[9] = 1'b1; settle();
    chk("R9 shared lane OR", 128'(fn_in[17]), 128'(1));
    pad_in[9] = 1'b0; pad_in[17] = 1'b1; settle();
    chk("R9 other function no contribution", 128'(fn_in[17]), 128'(0));
    // R10
    wr(3, 32'h0002_2205); pad_in[3] = 1'b1;
    rd(3, d); chk("R10 raw pad high", 128'(d[31]), 128'(1));
    pad_in[3] = 1'b0;
    rd(3, d); chk("R10 raw pad low", 128'(d[31]), 128'(0));
    // R11
    rd(29, keep);
    wr(30, 32'h5); wr(31, 32'h3);
    rd(30, d); chk("R11 oob read", 128'(d), 128'(0));
    rd(29, d); chk("R11 neighbour untouched", 128'(d), 128'(keep));
    // random phase, compared every cycle by the model
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      bus_wr    = ($urandom % 4) == 0;
      bus_rd    = ($urandom % 3) == 0;
      bus_addr  = 5'($urandom);
      bus_wdata = $urandom;
      if (($urandom % 2) == 0) bus_wdata[4:0] = 5'($urandom % 12);
      pad_in    = NP'({$urandom, $urandom});
      fn_out    = FN'({$urandom, $urandom, $urandom});
      fn_oe     = FN'({$urandom, $urandom, $urandom});
    end
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    settle();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule